// File: doc/BRIEF.md
# Flash Interrupt and Status Controller

This block is the host-visible control corner of a flash controller. It keeps four 16-bit registers (command, configuration, controller status and interrupt status), accepts command words from the host, posts the completion bit for each kind of operation, gathers error flags and drives an interrupt pin whose active level is chosen by a configuration bit. A ready pin follows another configuration bit.

Each command is modelled as finishing in the same cycle in which the host writes it. The `op_fail` input, sampled with that write, says whether the operation failed. The host port is a plain synchronous read/write port. Reads are registered and return one cycle later together with a valid strobe. A synchronous active-high `rst` gives the cold-reset values. A `warm_rst` pulse, or one of the two reset opcodes, gives the warm-reset values.

Top module: `flash_irq_ctrl`

## Requirements
- R1: After `rst` the interrupt register reads 0x8080, the status register 0x0000, the configuration register 0x40C0 and the command register 0x0000, with `irq` and `rdy` both high.
- R2: A `warm_rst` pulse, or an accepted command 0x00F0 or 0x00F3, gives the interrupt register 0x8010 and restores status 0x0000, configuration 0x40C0 and command 0x0000.
- R3: A host write to the interrupt register (address 0x0003) leaves the AND of the old value and the written word. If bit 15 of the result is 0, status bits 13..10 are cleared; otherwise they keep their value.
- R4: While interrupt bit 15 is 1, a write to the command register (address 0x0000) changes neither the command register nor any other register.
- R5: An accepted load opcode (0x0000, 0x0013) ORs bits 15 and 7 into the interrupt register. A program opcode (0x0080, 0x001A, 0x001B) ORs bits 15 and 6, and an erase opcode (0x0094, 0x0095, 0x0030) ORs bits 15 and 5.
- R6: When `op_fail` is high with an accepted command, status bit 10 (command error) is set. A load also sets bit 13, a program bit 12 and an erase bit 11. Any of the opcodes listed in R8 that sets bit 15 sets only bit 10.
- R7: An accepted opcode not listed in R2, R5 or R8 sets status bit 10 and interrupt bit 15, whatever the value of `op_fail`.
- R8: The opcodes 0x0023, 0x0027, 0x002A, 0x002C, 0x0071 and 0x0065 set only interrupt bit 15. Opcode 0x00B0 changes no interrupt or status bit. Both groups are stored in the command register.
- R9: `irq` equals interrupt bit 15 XOR the inverse of configuration bit 6, and `rdy` equals configuration bit 7.
- R10: The configuration register (address 0x0001) reads back as the written value ANDed with 0xFFE0. An accepted command word reads back unchanged from address 0x0000.
- R11: A read pulse at a clock edge gives `host_rvalid` and the data at the next edge. The status register (address 0x0002) is read-only, and any address outside 0x0000..0x0003 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| warm_rst | input | 1 | Synchronous warm-reset pulse |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | 16 | Write data or command word |
| op_fail | input | 1 | Failure flag of the command written in this cycle |
| host_rdata | output | 16 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after `host_rd` |
| irq | output | 1 | Interrupt pin, level set by configuration bit 6 |
| rdy | output | 1 | Ready pin, copy of configuration bit 7 |

## Verification
A register write takes effect at the edge that samples it, so `irq`, `rdy` and every register value are checked at the falling edge right after the write cycle. Read data is due one edge after the read strobe. The bench driver therefore queues the expected word when it issues a read, and a monitor pops it at the falling edge on which `host_rvalid` is high, so each result is compared in exactly the cycle it should appear. The tests that show a write had no effect (refused commands, writes to the status register) read the register back in the very next transaction.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;

    localparam int WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;

    // register map
    localparam word_t REG_CMD  = 16'h0000;
    localparam word_t REG_CFG  = 16'h0001;
    localparam word_t REG_STAT = 16'h0002;
    localparam word_t REG_INT  = 16'h0003;

    // reset values and masks
    localparam word_t INT_COLD    = 16'h8080;
    localparam word_t INT_WARM    = 16'h8010;
    localparam word_t CFG_INIT    = 16'h40C0;
    localparam word_t CFG_RD_MASK = 16'hFFE0;

    // interrupt bit positions
    localparam int INT_GLOBAL = 15;
    localparam int INT_LOAD   = 7;
    localparam int INT_PROG   = 6;
    localparam int INT_ERASE  = 5;

    // configuration bit positions
    localparam int CFG_POL = 6;
    localparam int CFG_RDY = 7;

    // status error field starts at this bit
    localparam int ERR_LSB = 10;

    typedef enum logic [2:0] {
        CL_LOAD,
        CL_PROG,
        CL_ERASE,
        CL_MARK,
        CL_QUIET,
        CL_WARM,
        CL_BAD
    } op_cls_e;

    // error flags, MSB first: status bits 13..10
    typedef struct packed {
        logic load;
        logic prog;
        logic erase;
        logic cmd;
    } err_t;

    localparam int ERR_W = $bits(err_t);

    function automatic op_cls_e classify(input word_t op);
        case (op)
            16'h0000, 16'h0013:                       return CL_LOAD;
            16'h0080, 16'h001A, 16'h001B:             return CL_PROG;
            16'h0094, 16'h0095, 16'h0030:             return CL_ERASE;
            16'h0023, 16'h0027, 16'h002A, 16'h002C,
            16'h0071, 16'h0065:                       return CL_MARK;
            16'h00B0:                                 return CL_QUIET;
            16'h00F0, 16'h00F3:                       return CL_WARM;
            default:                                  return CL_BAD;
        endcase
    endfunction

    function automatic word_t stat_word(input err_t e);
        word_t w;
        w = '0;
        w[ERR_LSB +: ERR_W] = e;
        return w;
    endfunction

endpackage

// File: rtl/fic_cmd_decode.sv
module fic_cmd_decode
    import flash_irq_pkg::*;
(
    input  word_t   op,
    input  logic    fail,
    output op_cls_e cls,
    output word_t   int_set,
    output err_t    err_set
);

    always_comb begin
        cls     = classify(op);
        int_set = '0;
        err_set = '0;
        case (cls)
            CL_LOAD: begin
                int_set[INT_GLOBAL] = 1'b1;
                int_set[INT_LOAD]   = 1'b1;
                err_set.cmd         = fail;
                err_set.load        = fail;
            end
            CL_PROG: begin
                int_set[INT_GLOBAL] = 1'b1;
                int_set[INT_PROG]   = 1'b1;
                err_set.cmd         = fail;
                err_set.prog        = fail;
            end
            CL_ERASE: begin
                int_set[INT_GLOBAL] = 1'b1;
                int_set[INT_ERASE]  = 1'b1;
                err_set.cmd         = fail;
                err_set.erase       = fail;
            end
            CL_MARK: begin
                int_set[INT_GLOBAL] = 1'b1;
                err_set.cmd         = fail;
            end
            CL_BAD: begin
                int_set[INT_GLOBAL] = 1'b1;
                err_set.cmd         = 1'b1;
            end
            default: begin
                int_set = '0;
                err_set = '0;
            end
        endcase
    end

endmodule

// File: rtl/fic_status_regs.sv
module fic_status_regs
    import flash_irq_pkg::*;
#(
    parameter int ADDR_W = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              warm_rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    input  op_cls_e           cls,
    input  word_t             int_set,
    input  err_t              err_set,
    output word_t             cmd_q,
    output word_t             cfg_q,
    output word_t             istat_q,
    output err_t              estat_q
);

    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(REG_CMD);
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(REG_CFG);
    localparam logic [ADDR_W-1:0] A_INT = ADDR_W'(REG_INT);

    word_t ack_val;
    logic  cmd_ok;

    assign ack_val = istat_q & wdata;
    assign cmd_ok  = wr && (addr == A_CMD) && !istat_q[INT_GLOBAL];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            cfg_q   <= CFG_INIT;
            istat_q <= INT_COLD;
            estat_q <= '0;
        end else if (warm_rst || (cmd_ok && cls == CL_WARM)) begin
            cmd_q   <= '0;
            cfg_q   <= CFG_INIT;
            istat_q <= INT_WARM;
            estat_q <= '0;
        end else if (cmd_ok) begin
            cmd_q   <= wdata;
            istat_q <= istat_q | int_set;
            estat_q <= estat_q | err_set;
        end else if (wr && addr == A_CFG) begin
            cfg_q <= wdata;
        end else if (wr && addr == A_INT) begin
            istat_q <= ack_val;
            if (!ack_val[INT_GLOBAL]) begin
                estat_q <= '0;
            end
        end
    end

endmodule

// File: rtl/fic_host_read.sv
module fic_host_read
    import flash_irq_pkg::*;
#(
    parameter int ADDR_W = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             cmd_q,
    input  word_t             cfg_q,
    input  word_t             istat_q,
    input  err_t              estat_q,
    output word_t             rdata,
    output logic              rvalid
);

    word_t sel;

    always_comb begin
        sel = '0;
        if (addr == ADDR_W'(REG_CMD))  sel = cmd_q;
        if (addr == ADDR_W'(REG_CFG))  sel = cfg_q & CFG_RD_MASK;
        if (addr == ADDR_W'(REG_STAT)) sel = stat_word(estat_q);
        if (addr == ADDR_W'(REG_INT))  sel = istat_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            if (rd) begin
                rdata <= sel;
            end
        end
    end

endmodule

// File: rtl/flash_irq_ctrl.sv
module flash_irq_ctrl
    import flash_irq_pkg::*;
#(
    parameter int ADDR_W = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              warm_rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    input  logic              op_fail,
    output logic [15:0]       host_rdata,
    output logic              host_rvalid,
    output logic              irq,
    output logic              rdy
);

    op_cls_e op_cls;
    word_t   int_set;
    err_t    err_set;
    word_t   cmd_q;
    word_t   cfg_q;
    word_t   istat_q;
    err_t    estat_q;

    fic_cmd_decode u_dec (
        .op      (host_wdata),
        .fail    (op_fail),
        .cls     (op_cls),
        .int_set (int_set),
        .err_set (err_set)
    );

    fic_status_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .warm_rst (warm_rst),
        .wr       (host_wr),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .cls      (op_cls),
        .int_set  (int_set),
        .err_set  (err_set),
        .cmd_q    (cmd_q),
        .cfg_q    (cfg_q),
        .istat_q  (istat_q),
        .estat_q  (estat_q)
    );

    fic_host_read #(.ADDR_W(ADDR_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd      (host_rd),
        .addr    (host_addr),
        .cmd_q   (cmd_q),
        .cfg_q   (cfg_q),
        .istat_q (istat_q),
        .estat_q (estat_q),
        .rdata   (host_rdata),
        .rvalid  (host_rvalid)
    );

    assign irq = istat_q[INT_GLOBAL] ^ ~cfg_q[CFG_POL];
    assign rdy = cfg_q[CFG_RDY];

endmodule

// File: rtl/flash_irq_ctrl_chk.sv
module flash_irq_ctrl_chk
    import flash_irq_pkg::*;
#(
    parameter int ADDR_W = 16
)(
    input logic              clk,
    input logic              rst,
    input logic              warm_rst,
    input logic              host_wr,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr,
    input logic [15:0]       host_wdata,
    input logic              host_rvalid,
    input logic              rdy,
    input op_cls_e           op_cls,
    input word_t             cmd_q,
    input word_t             istat_q,
    input err_t              estat_q
);

    logic to_cmd, to_cfg, to_int;
    assign to_cmd = host_wr && host_addr == ADDR_W'(REG_CMD) && !warm_rst;
    assign to_cfg = host_wr && host_addr == ADDR_W'(REG_CFG) && !warm_rst;
    assign to_int = host_wr && host_addr == ADDR_W'(REG_INT) && !warm_rst;

    p_warm_val_r2: assert property (@(posedge clk) disable iff (rst)
        warm_rst |=> istat_q == INT_WARM && estat_q == '0);

    p_ack_wipes_err_r3: assert property (@(posedge clk) disable iff (rst)
        to_int && !host_wdata[INT_GLOBAL] |=> estat_q == '0 && !istat_q[INT_GLOBAL]);

    p_refuse_cmd_r4: assert property (@(posedge clk) disable iff (rst)
        to_cmd && istat_q[INT_GLOBAL] |=> $stable(cmd_q) && $stable(istat_q));

    p_err_has_cmd_r6: assert property (@(posedge clk) disable iff (rst)
        (estat_q.load || estat_q.prog || estat_q.erase) |-> estat_q.cmd);

    p_unknown_r7: assert property (@(posedge clk) disable iff (rst)
        to_cmd && !istat_q[INT_GLOBAL] && op_cls == CL_BAD
        |=> istat_q[INT_GLOBAL] && estat_q.cmd);

    p_rdy_follow_r9: assert property (@(posedge clk) disable iff (rst)
        to_cfg |=> rdy == $past(host_wdata[CFG_RDY]));

    p_read_lat_r11: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> host_rvalid);

    p_no_spurious_r11: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> !host_rvalid);

endmodule

bind flash_irq_ctrl flash_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .warm_rst    (warm_rst),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rvalid (host_rvalid),
    .rdy         (rdy),
    .op_cls      (op_cls),
    .cmd_q       (cmd_q),
    .istat_q     (istat_q),
    .estat_q     (estat_q)
);

// File: tb/flash_irq_ctrl_bench.sv
module flash_irq_ctrl_bench;

    localparam int AW = 16;
    localparam logic [15:0] A_CMD  = 16'h0000;
    localparam logic [15:0] A_CFG  = 16'h0001;
    localparam logic [15:0] A_STAT = 16'h0002;
    localparam logic [15:0] A_INT  = 16'h0003;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          warm_rst = 1'b0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [15:0]   host_wdata = '0;
    logic          op_fail = 1'b0;
    logic [15:0]   host_rdata;
    logic          host_rvalid;
    logic          irq;
    logic          rdy;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    flash_irq_ctrl #(.ADDR_W(AW)) u_flash_irq_ctrl (
        .clk         (clk),
        .rst         (rst),
        .warm_rst    (warm_rst),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .op_fail     (op_fail),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .irq         (irq),
        .rdy         (rdy)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic f);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d; op_fail = f;
        @(negedge clk);
        host_wr = 1'b0; op_fail = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic pulse_warm();
        @(negedge clk);
        warm_rst = 1'b1;
        @(negedge clk);
        warm_rst = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && host_rvalid) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected rvalid", 16'h0001, 16'h0000);
            end else begin
                chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 cold reset state
        chk("R1 irq after reset", {15'd0, irq}, 16'h0001);
        chk("R1 rdy after reset", {15'd0, rdy}, 16'h0001);
        chk("R11 idle rvalid", {15'd0, host_rvalid}, 16'h0000);
        rd(A_INT,  16'h8080, "R1 int cold");
        rd(A_STAT, 16'h0000, "R1 stat cold");
        rd(A_CFG,  16'h40C0, "R1 cfg cold");
        rd(A_CMD,  16'h0000, "R1 cmd cold");

        // R4 refused while bit15 set
        wr(A_CMD, 16'h0095, 1'b1);
        rd(A_CMD,  16'h0000, "R4 cmd unchanged");
        rd(A_INT,  16'h8080, "R4 int unchanged");
        rd(A_STAT, 16'h0000, "R4 stat unchanged");

        // R3 ack, R9 irq follows bit15
        wr(A_INT, 16'h0000, 1'b0);
        rd(A_INT, 16'h0000, "R3 int acked");
        chk("R9 irq low after ack", {15'd0, irq}, 16'h0000);

        // R5 load, R10 command readback
        wr(A_CMD, 16'h0013, 1'b0);
        chk("R9 irq after load", {15'd0, irq}, 16'h0001);
        rd(A_INT,  16'h8080, "R5 load bits");
        rd(A_CMD,  16'h0013, "R10 cmd readback");
        rd(A_STAT, 16'h0000, "R6 no error on success");
        wr(A_INT, 16'h7FFF, 1'b0);
        rd(A_INT, 16'h0080, "R3 and-mask keeps bit7");
        wr(A_CMD, 16'h0080, 1'b0);
        rd(A_INT, 16'h80C0, "R5 program bits ored");
        wr(A_INT, 16'h0000, 1'b0);

        // R6 program failure, R3 keeps/clears errors
        wr(A_CMD, 16'h001A, 1'b1);
        rd(A_INT,  16'h8040, "R5 program bits");
        rd(A_STAT, 16'h1400, "R6 program error");
        wr(A_INT, 16'h8000, 1'b0);
        rd(A_INT,  16'h8000, "R3 bit15 kept");
        rd(A_STAT, 16'h1400, "R3 errors kept");
        wr(A_INT, 16'h0000, 1'b0);
        rd(A_STAT, 16'h0000, "R3 errors wiped");

        // R6 erase failure
        wr(A_CMD, 16'h0095, 1'b1);
        rd(A_INT,  16'h8020, "R5 erase bits");
        rd(A_STAT, 16'h0C00, "R6 erase error");
        wr(A_INT, 16'h0000, 1'b0);

        // R6 load failure
        wr(A_CMD, 16'h0000, 1'b1);
        rd(A_INT,  16'h8080, "R5 load 0x0000");
        rd(A_STAT, 16'h2400, "R6 load error");
        wr(A_INT, 16'h0000, 1'b0);

        // R5 erase resume, copy-back program
        wr(A_CMD, 16'h0030, 1'b0);
        rd(A_INT, 16'h8020, "R5 erase resume");
        wr(A_INT, 16'h0000, 1'b0);
        wr(A_CMD, 16'h001B, 1'b0);
        rd(A_INT, 16'h8040, "R5 copy-back program");
        wr(A_INT, 16'h0000, 1'b0);

        // R7 unknown opcode
        wr(A_CMD, 16'h0042, 1'b0);
        rd(A_INT,  16'h8000, "R7 unknown int");
        rd(A_STAT, 16'h0400, "R7 unknown error");
        wr(A_INT, 16'h0000, 1'b0);

        // R8 marker and quiet opcodes
        wr(A_CMD, 16'h0023, 1'b0);
        rd(A_INT,  16'h8000, "R8 marker int");
        rd(A_STAT, 16'h0000, "R8 marker no error");
        wr(A_INT, 16'h0000, 1'b0);
        wr(A_CMD, 16'h002C, 1'b1);
        rd(A_STAT, 16'h0400, "R6 marker failure");
        wr(A_INT, 16'h0000, 1'b0);
        wr(A_CMD, 16'h00B0, 1'b0);
        rd(A_INT, 16'h0000, "R8 quiet int");
        rd(A_CMD, 16'h00B0, "R8 quiet stored");
        chk("R8 quiet irq", {15'd0, irq}, 16'h0000);

        // R9 / R10 configuration
        wr(A_CFG, 16'h0080, 1'b0);
        chk("R9 irq inverted level", {15'd0, irq}, 16'h0001);
        chk("R9 rdy high", {15'd0, rdy}, 16'h0001);
        rd(A_CFG, 16'h0080, "R10 cfg readback");
        wr(A_CFG, 16'h001F, 1'b0);
        chk("R9 rdy low", {15'd0, rdy}, 16'h0000);
        rd(A_CFG, 16'h0000, "R10 cfg low bits masked");
        wr(A_CFG, 16'hFFFF, 1'b0);
        chk("R9 irq normal level", {15'd0, irq}, 16'h0000);
        rd(A_CFG, 16'hFFE0, "R10 cfg mask");

        // R2 warm reset by command
        wr(A_CMD, 16'h00F3, 1'b0);
        rd(A_INT,  16'h8010, "R2 int warm cmd");
        rd(A_CFG,  16'h40C0, "R2 cfg warm cmd");
        rd(A_CMD,  16'h0000, "R2 cmd warm cmd");
        chk("R2 rdy warm", {15'd0, rdy}, 16'h0001);

        // R2 warm reset by pin, clears errors
        wr(A_INT, 16'h0000, 1'b0);
        wr(A_CMD, 16'h0094, 1'b1);
        rd(A_STAT, 16'h0C00, "R6 erase 0x0094 error");
        pulse_warm();
        rd(A_INT,  16'h8010, "R2 int warm pin");
        rd(A_STAT, 16'h0000, "R2 stat warm pin");

        // R2 warm reset by 0x00F0
        wr(A_INT, 16'h0000, 1'b0);
        wr(A_CFG, 16'h0000, 1'b0);
        wr(A_CMD, 16'h00F0, 1'b0);
        rd(A_CFG, 16'h40C0, "R2 cfg warm 0x00F0");
        rd(A_INT, 16'h8010, "R2 int warm 0x00F0");

        // R11 read-only status, unmapped addresses
        wr(A_INT, 16'h0000, 1'b0);
        wr(A_STAT, 16'hFFFF, 1'b0);
        rd(A_STAT, 16'h0000, "R11 stat read-only");
        rd(16'h0077, 16'h0000, "R11 unmapped read");
        rd(16'hF241, 16'h0000, "R11 unmapped high read");

        repeat (3) @(negedge clk);
        chk("R11 queue drained", 16'(exp_q.size()), 16'h0000);
        finish_run();
    end

endmodule